// File: doc/BRIEF.md
# ADC Engine Control and Channel Sequencer

This block is the digital control core of a multi-channel successive-approximation converter. It holds a 32-bit engine control word with an engine enable, a three-bit operating mode, a reference selector, a read-only initialization-ready flag, two channel-7 battery sensing bits and one enable bit per channel. The converter itself sits outside the block. It offers a result on a valid/ready stream. The sequencer names the channel that the next accepted result belongs to and stores each accepted result in that channel's halfword data register.

The sequencer steps through the enabled channels in ascending order, skips any channel whose enable bit is clear, and wraps from the highest channel to the lowest. Conversions are accepted only while the engine is enabled and the mode is normal. In every other state, and whenever no channel is enabled, the stream ready signal stays low and all data registers keep their values.

The ready flag rises after a parameterised number of sample strobes have been seen in normal operation. It clears as soon as the engine leaves normal operation. Software uses a simple memory-mapped port with combinational reads and single-cycle writes.

Stream rules: `smp_chan` is meaningful only while `smp_ready` is high. A result is taken on a clock edge where `smp_valid` and `smp_ready` are both high. A strobe with `smp_ready` low is discarded and is never stored. Every strobe in normal operation advances the ready counter, whether or not it is taken. The converter need not hold `smp_valid` after a refusal.

Top module: `adc_seq_core`

## Requirements
- R1: After reset the control word reads 0 (powered down, disabled, no channels enabled, ready flag clear), every data register reads 0, and `smp_ready` is low.
- R2: A write to address 0x00 updates the writable control bits. These are bit 0 (enable), bits [3:1] (mode), bits [7:6] (reference select), bit 12 (channel 7 battery mode), bit 13 (battery sensing enable) and bits [31:16] (channel n enable at bit 16+n). A read of 0x00 returns these bits, with the ready flag in bit 8 and zero in every other bit.
- R3: `smp_ready` is high only while bit 0 is 1, the mode is 7 (normal) and at least one channel is enabled. A mode of 0 (power-down), 1 (standby) or any other value refuses all results, and the data registers keep their values.
- R4: Accepted results go to the enabled channels in ascending order, wrapping from channel 15 to channel 0. The search starts at the channel after the last one written, and disabled channels are skipped.
- R5: With no channel enable bit set, `smp_ready` stays low and no data register changes.
- R6: The result for channel n is read at byte address 0x10 + 2n (0x10 to 0x2E). It is the 10-bit result zero-extended, and bits [31:10] of the read are zero.
- R7: Bit 8 becomes 1 after INIT_STROBES sample strobes (default 4) have been seen while in normal operation. It returns to 0 once the engine is disabled or the mode leaves 7.
- R8: Writes to any address other than 0x00 have no effect, including writes to the data register addresses.
- R9: Reads from unmapped addresses (0x04, odd addresses, and addresses at or above 0x30) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| smp_valid | input | 1 | Converter offers a result |
| smp_ready | output | 1 | Sequencer will take the offered result |
| smp_chan | output | 4 | Channel that the offered result belongs to |
| smp_data | input | 10 | Conversion result |

## Verification
The assertions assume that the converter changes `smp_data` and `smp_valid` only away from the clock edge. They also assume that software writes the control word no more than once per cycle. The stimulus drives every input on the falling edge and raises `smp_valid` for a single cycle per strobe. It writes mode values both inside the defined set and outside it (6), so the refusal rules are exercised for legal and illegal modes. Channel masks include a full mask, sparse masks, a mask whose only channels are 15 and 0, and an empty mask. Together these exercise skipping and the wrap-around in the order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int        CTRL_W     = 32;
  localparam int        ADDR_W     = 8;
  localparam int        EN_LSB     = 16;
  localparam int        RDY_BIT    = 8;
  localparam logic [31:0] FIXED_WMASK = 32'h0000_30CF;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] DATA_BASE = 8'h10;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_STBY = 3'd1,
    MODE_RUN  = 3'd7
  } op_mode_e;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 16,
  parameter int INIT_STROBES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              smp_valid,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              init_rdy,
  output logic              run,
  output logic [NCH-1:0]    chan_en
);
  localparam int CNT_W = (INIT_STROBES < 2) ? 1 : $clog2(INIT_STROBES);
  localparam logic [CTRL_W-1:0] EN_MASK = ((CTRL_W'(1) << NCH) - CTRL_W'(1)) << EN_LSB;
  localparam logic [CTRL_W-1:0] WMASK   = FIXED_WMASK | EN_MASK;
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(INIT_STROBES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata & WMASK;
  end

  assign run     = ctrl_q[0] && (ctrl_q[3:1] == MODE_RUN);
  assign chan_en = ctrl_q[EN_LSB +: NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      init_rdy <= 1'b0;
    end else if (!run) begin
      cnt_q    <= '0;
      init_rdy <= 1'b0;
    end else if (smp_valid && !init_rdy) begin
      if (cnt_q == LAST) init_rdy <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rr_pick.sv
module adc_rr_pick #(
  parameter int NCH  = 16,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  chan_en,
  input  logic [CH_W-1:0] start,
  output logic            any,
  output logic [CH_W-1:0] pick
);
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 0; k < NCH; k++) begin
      int idx;
      idx = (int'(start) + k) % NCH;
      if (!any && chan_en[idx]) begin
        any  = 1'b1;
        pick = idx[CH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_data_bank.sv
module adc_data_bank
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_idx,
  input  logic [RES_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CTRL_W-1:0]    rd_data,
  output logic [NCH*RES_W-1:0] data_flat
);
  localparam logic [ADDR_W-1:0] TOP = DATA_BASE + ADDR_W'(2 * NCH);

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [CH_W-1:0]   rd_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [RES_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (wr_en && wr_idx == CH_W'(g)) val_q <= wr_data;
    end
    assign data_flat[g*RES_W +: RES_W] = val_q;
  end

  assign off    = rd_addr - DATA_BASE;
  assign hit    = (rd_addr >= DATA_BASE) && (rd_addr < TOP) && !rd_addr[0];
  assign rd_idx = off[CH_W:1];
  assign rd_data = hit ? CTRL_W'(data_flat[rd_idx*RES_W +: RES_W]) : '0;
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NCH          = 16,
  parameter int RES_W        = 10,
  parameter int INIT_STROBES = 4,
  localparam int CH_W        = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  output logic [CH_W-1:0]   smp_chan,
  input  logic [RES_W-1:0]  smp_data
);
  logic [CTRL_W-1:0]    ctrl_q;
  logic                 init_rdy, run, any, accept;
  logic [NCH-1:0]       chan_en;
  logic [CH_W-1:0]      ptr_q, pick;
  logic [CTRL_W-1:0]    bank_rd;
  logic [NCH*RES_W-1:0] data_flat;

  adc_ctrl_reg #(.NCH(NCH), .INIT_STROBES(INIT_STROBES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(bus_wr && bus_addr == CTRL_ADDR), .wdata(bus_wdata),
    .smp_valid(smp_valid), .ctrl_q(ctrl_q), .init_rdy(init_rdy),
    .run(run), .chan_en(chan_en)
  );

  adc_rr_pick #(.NCH(NCH)) u_pick (
    .chan_en(chan_en), .start(ptr_q), .any(any), .pick(pick)
  );

  assign smp_ready = run && any;
  assign smp_chan  = pick;
  assign accept    = smp_valid && smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (accept) ptr_q <= (pick == CH_W'(NCH - 1)) ? '0 : pick + 1'b1;
  end

  adc_data_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_idx(pick),
    .wr_data(smp_data), .rd_addr(bus_addr), .rd_data(bank_rd),
    .data_flat(data_flat)
  );

  always_comb begin
    bus_rdata = bank_rd;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata          = ctrl_q;
      bus_rdata[RDY_BIT] = init_rdy;
    end
  end
endmodule

// File: rtl/adc_seq_core_chk.sv
module adc_seq_core_chk
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int CH_W  = $clog2(NCH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic [CH_W-1:0]      smp_chan,
  input logic [CTRL_W-1:0]    ctrl_q,
  input logic [NCH-1:0]       chan_en,
  input logic                 init_rdy,
  input logic [NCH*RES_W-1:0] data_flat,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [CTRL_W-1:0]    bus_rdata
);
  logic normal;
  assign normal = ctrl_q[0] && (ctrl_q[3:1] == MODE_RUN);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> $stable(data_flat));

  assert_chan_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> chan_en[smp_chan]);

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en == '0) |-> !smp_ready);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= DATA_BASE && bus_addr < DATA_BASE + ADDR_W'(2 * NCH))
      |-> (bus_rdata[CTRL_W-1:RES_W] == '0));

  assert_rdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !normal |=> !init_rdy);

  assert_rdy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_rdy) |-> $past(smp_valid));
endmodule

bind adc_seq_core adc_seq_core_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_chan(smp_chan), .ctrl_q(ctrl_q), .chan_en(chan_en),
  .init_rdy(init_rdy), .data_flat(data_flat), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/adc_seq_core_test.sv
module adc_seq_core_test;
  localparam int NCH = 16;
  localparam int INIT_N = 4;
  localparam logic [31:0] WMASK = 32'hFFFF_30CF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [3:0]  smp_chan;
  logic [9:0]  smp_data = '0;

  int checks = 0;
  int errors = 0;

  logic [9:0]  m_data [NCH];
  logic [31:0] m_ctrl;
  int          m_ptr, m_cnt, m_seed;
  logic        m_rdy;

  // control word, strobe count
  localparam logic [39:0] VEC [7] = '{
    {32'hFFFF_000F, 8'd20},
    {32'h00A5_000F, 8'd7},
    {32'h8001_000F, 8'd5},
    {32'h0080_30CF, 8'd3},
    {32'h00F0_000D, 8'd4},
    {32'hFFFF_0003, 8'd4},
    {32'h0000_000F, 8'd3}
  };

  always #10 clk = ~clk;

  adc_seq_core uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_chan(smp_chan), .smp_data(smp_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_run();
    return m_ctrl[0] && (m_ctrl[3:1] == 3'd7);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h00) begin
      m_ctrl = d & WMASK;
      if (!m_run()) begin m_cnt = 0; m_rdy = 1'b0; end
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic strobe();
    int pick;
    logic any;
    logic [9:0] val;
    @(negedge clk);
    any = 1'b0; pick = 0;
    for (int k = 0; k < NCH; k++) begin
      int i;
      i = (m_ptr + k) % NCH;
      if (!any && m_ctrl[16 + i]) begin any = 1'b1; pick = i; end
    end
    #1;
    check("R3/R5 smp_ready", 32'(smp_ready), 32'(m_run() && any));
    if (m_run() && any) check("R4 smp_chan", 32'(smp_chan), 32'(pick));
    m_seed++;
    val = 10'((m_seed * 37 + pick * 13) & 10'h3FF);
    smp_data = val; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    if (m_run()) begin
      if (!m_rdy) begin
        if (m_cnt == INIT_N - 1) m_rdy = 1'b1; else m_cnt++;
      end
      if (any) begin
        m_data[pick] = val;
        m_ptr = (pick + 1) % NCH;
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(8'h00, v);
    check({"R2 ctrl ", tag}, v, m_ctrl | (32'(m_rdy) << 8));
    for (int n = 0; n < NCH; n++) begin
      rd(8'(8'h10 + 2 * n), v);
      check({"R6 data ", tag}, v, 32'(m_data[n]));
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < NCH; n++) m_data[n] = '0;
    m_ctrl = '0; m_ptr = 0; m_cnt = 0; m_seed = 0; m_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 smp_ready", 32'(smp_ready), 32'd0);
    rd(8'h00, v); check("R1 ctrl", v, 32'd0);
    rd(8'h10, v); check("R1 data0", v, 32'd0);
    rd(8'h2E, v); check("R1 data15", v, 32'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int t = 0; t < 7; t++) begin
      wr(8'h00, VEC[t][39:8]);
      for (int s = 0; s < int'(VEC[t][7:0]); s++) strobe();
      check_all($sformatf("vec%0d", t));
    end

    // R2 read-only and unused bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 mask", v & ~32'h100, 32'hFFFF_30CF);

    // R7 ready flag clears and re-arms
    wr(8'h00, 32'h0004_0003);
    rd(8'h00, v); check("R7 clear standby", 32'(v[8]), 32'd0);
    wr(8'h00, 32'h0004_000F);
    rd(8'h00, v); check("R7 clear on entry", 32'(v[8]), 32'd0);
    for (int s = 0; s < INIT_N - 1; s++) strobe();
    rd(8'h00, v); check("R7 not yet", 32'(v[8]), 32'd0);
    strobe();
    rd(8'h00, v); check("R7 set", 32'(v[8]), 32'd1);
    wr(8'h00, 32'h0004_000E);
    rd(8'h00, v); check("R7 clear disable", 32'(v[8]), 32'd0);

    // R8 writes elsewhere ignored
    wr(8'h14, 32'h0000_03FF);
    rd(8'h14, v); check("R8 data write", v, 32'(m_data[2]));
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R8 ctrl kept", v, m_ctrl | (32'(m_rdy) << 8));

    // R9 unmapped reads
    rd(8'h04, v); check("R9 0x04", v, 32'd0);
    rd(8'h11, v); check("R9 odd", v, 32'd0);
    rd(8'h30, v); check("R9 0x30", v, 32'd0);
    rd(8'hFE, v); check("R9 0xFE", v, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule